// File: doc/BRIEF.md
# Cross-Domain Capture Hold Controller

This block drives the scan-side control for flops that sit on paths crossing between asynchronous clock domains, and for source flops of multicycle or false paths inside a domain. It lets all such paths be exercised at speed in the same pattern without masking unknown results. In each pattern only one domain, chosen by a select code captured during shift, may capture on its receiving flops. Receive flops in every other domain are held at their scanned-in value. Transmit flops that feed the capturing domain are frozen long enough to give every crossing path a margin of at least eight shift periods.

The controller runs on the slow scan-control clock. Per-domain burst and capture strobes arrive already aligned to that clock from each domain's burst sequencer. A `shift_tick` pulse marks each shift-clock period, and the release window is measured in those pulses. Multicycle source flops get an update enable only on every N-th burst cycle of their domain, counted from the end of shift. When the burst length is a multiple of N, the last update coincides with the capture edge. With test mode low every output is inactive, so functional operation is untouched.

Top module: `xdom_capture_hold`

## Requirements
- R1: After reset the selected domain is 0 and the transmit release window is not open: with test mode high and shift low, `rx_inhibit` and `tx_hold` are high for every domain except 0, and `mc_hold` is high for all domains.
- R2: `dom_sel` (binary domain index) is taken on each clock edge where test mode and shift are both high and the code is below the domain count. Codes of the domain count or above are ignored, and the code is ignored outside shift. The new value governs the outputs from the next cycle on.
- R3: While test mode is high and shift is low, `rx_inhibit[d]` is high exactly for the domains d other than the selected one.
- R4: While test mode is high and shift is low, `tx_hold[d]` is high for every non-selected domain d until the window is released. It is never high for the selected domain.
- R5: The window opens at the first `cap_stb` bit of the selected domain seen outside shift. It releases on the HOLD_TICKS-th `shift_tick` after that edge; a tick in the same cycle as the strobe does not count. `tx_hold` is low from the following cycle. Capture strobes of other domains have no effect.
- R6: Outside shift in test mode, `mc_hold[d]` is low only in cycles where `burst_act[d]` is high and it is the MC_N-th, 2·MC_N-th, … burst cycle of domain d since shift ended. Otherwise it is high.
- R7: While shift is high, all outputs are low, the phase counts restart, and any open or released window is cleared.
- R8: While test mode is low, all outputs are low whatever the strobes do. The window and phase state are cleared, and the selected domain is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan-control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_mode | input | 1 | High while scan test is active |
| shift_phase | input | 1 | High during scan shift, low during burst and capture |
| shift_tick | input | 1 | One pulse per shift-clock period |
| dom_sel | input | $clog2(NUM_DOM) | Index of the domain that captures in this pattern |
| burst_act | input | NUM_DOM | Per-domain burst-cycle strobe |
| cap_stb | input | NUM_DOM | Per-domain capture strobe |
| rx_inhibit | output | NUM_DOM | Capture inhibit for each domain's receive flops |
| tx_hold | output | NUM_DOM | Freeze for each domain's transmit flops |
| mc_hold | output | NUM_DOM | Hold for each domain's multicycle source flops |

## Verification
The bench builds the block with three domains, MC_N of 3 and HOLD_TICKS of 8. Three domains leave one two-bit select code unused, so the ignored out-of-range code can be reached. An MC_N that is not a power of two selects the explicitly wrapping phase counter. The default build uses the naturally wrapping one. The minimum hold count lets the release window close within short idle tails at several tick rates, and also be cut off by a new shift before it closes.

// File: rtl/xdom_hold_pkg.sv
package xdom_hold_pkg;
   // smallest release window allowed, in shift periods
   localparam int unsigned HOLD_FLOOR = 8;
   // smallest multicycle ratio allowed
   localparam int unsigned MC_FLOOR   = 2;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/xdom_sel_reg.sv
module xdom_sel_reg #(
   parameter int unsigned NUM_DOM = 4,
   localparam int unsigned SEL_W  = $clog2(NUM_DOM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_mode,
   input  logic               shift_phase,
   input  logic [SEL_W-1:0]   dom_sel,
   output logic [SEL_W-1:0]   sel_q,
   output logic [NUM_DOM-1:0] sel_oh
);
   localparam logic [SEL_W:0] DOM_LIM = (SEL_W+1)'(NUM_DOM);

   logic code_ok;
   assign code_ok = ({1'b0, dom_sel} < DOM_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (test_mode && shift_phase && code_ok)
         sel_q <= dom_sel;
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dec
      assign sel_oh[d] = (sel_q == SEL_W'(d));
   end

   // R2
   sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_phase |=> $stable(sel_q));
   // R2
   sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(sel_oh));
endmodule

// File: rtl/xdom_tx_window.sv
module xdom_tx_window #(
   parameter int unsigned NUM_DOM    = 4,
   parameter int unsigned HOLD_TICKS = 8,
   localparam int unsigned CW        = $clog2(HOLD_TICKS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_mode,
   input  logic               shift_phase,
   input  logic               shift_tick,
   input  logic [NUM_DOM-1:0] cap_stb,
   input  logic [NUM_DOM-1:0] sel_oh,
   output logic               released
);
   logic          armed;
   logic [CW-1:0] cnt;
   logic          cap_sel;

   assign cap_sel = |(cap_stb & sel_oh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         released <= 1'b0;
         cnt      <= '0;
      end else if (!test_mode || shift_phase) begin
         armed    <= 1'b0;
         released <= 1'b0;
         cnt      <= '0;
      end else if (armed) begin
         if (shift_tick) begin
            if (cnt == CW'(1)) begin
               armed    <= 1'b0;
               released <= 1'b1;
               cnt      <= '0;
            end else begin
               cnt <= cnt - CW'(1);
            end
         end
      end else if (!released && cap_sel) begin
         armed <= 1'b1;
         cnt   <= CW'(HOLD_TICKS);
      end
   end

   // R5
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(HOLD_TICKS));
   // R5
   win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(armed && released));
   // R5
   win_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(released) |-> ($past(armed) && $past(shift_tick)));
   // R7
   win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_phase |=> (!released && !armed));
endmodule

// File: rtl/xdom_mc_gate.sv
module xdom_mc_gate
   import xdom_hold_pkg::*;
#(
   parameter int unsigned MC_N = 4,
   localparam int unsigned PW  = $clog2(MC_N)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic burst_act,
   output logic upd_ok
);
   localparam logic [PW-1:0] LAST = PW'(MC_N - 1);

   logic [PW-1:0] ph;

   if (is_pow2(MC_N)) begin : g_pow2
      // counter width matches the ratio, so it wraps by itself
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ph <= '0;
         else if (!run)      ph <= '0;
         else if (burst_act) ph <= ph + PW'(1);
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ph <= '0;
         else if (!run)      ph <= '0;
         else if (burst_act) ph <= (ph == LAST) ? '0 : ph + PW'(1);
      end
   end

   assign upd_ok = run & burst_act & (ph == LAST);

   // R6
   mc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph <= LAST);
   // R6
   mc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_ok |=> !upd_ok);
endmodule

// File: rtl/xdom_capture_hold.sv
module xdom_capture_hold
   import xdom_hold_pkg::*;
#(
   parameter int unsigned NUM_DOM    = 4,
   parameter int unsigned MC_N       = 4,
   parameter int unsigned HOLD_TICKS = 8,
   localparam int unsigned SEL_W     = $clog2(NUM_DOM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               test_mode,
   input  logic               shift_phase,
   input  logic               shift_tick,
   input  logic [SEL_W-1:0]   dom_sel,
   input  logic [NUM_DOM-1:0] burst_act,
   input  logic [NUM_DOM-1:0] cap_stb,
   output logic [NUM_DOM-1:0] rx_inhibit,
   output logic [NUM_DOM-1:0] tx_hold,
   output logic [NUM_DOM-1:0] mc_hold
);
   if (NUM_DOM < 2) begin : g_bad_dom
      $error("xdom_capture_hold: NUM_DOM must be at least 2");
   end
   if (MC_N < MC_FLOOR) begin : g_bad_mc
      $error("xdom_capture_hold: MC_N below the allowed floor");
   end
   if (HOLD_TICKS < HOLD_FLOOR) begin : g_bad_hold
      $error("xdom_capture_hold: HOLD_TICKS below the allowed floor");
   end

   logic               run;
   logic [SEL_W-1:0]   sel_q;
   logic [NUM_DOM-1:0] sel_oh;
   logic               released;
   logic [NUM_DOM-1:0] upd_ok;

   assign run = test_mode & ~shift_phase;

   xdom_sel_reg #(.NUM_DOM(NUM_DOM)) i_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_mode   (test_mode),
      .shift_phase (shift_phase),
      .dom_sel     (dom_sel),
      .sel_q       (sel_q),
      .sel_oh      (sel_oh)
   );

   xdom_tx_window #(.NUM_DOM(NUM_DOM), .HOLD_TICKS(HOLD_TICKS)) i_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .test_mode   (test_mode),
      .shift_phase (shift_phase),
      .shift_tick  (shift_tick),
      .cap_stb     (cap_stb),
      .sel_oh      (sel_oh),
      .released    (released)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_mc
      xdom_mc_gate #(.MC_N(MC_N)) i_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run),
         .burst_act (burst_act[d]),
         .upd_ok    (upd_ok[d])
      );
   end

   assign rx_inhibit = {NUM_DOM{run}} & ~sel_oh;
   assign tx_hold    = {NUM_DOM{run & ~released}} & ~sel_oh;
   assign mc_hold    = {NUM_DOM{run}} & ~upd_ok;

   // R8
   tm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !test_mode |-> (rx_inhibit == '0 && tx_hold == '0 && mc_hold == '0));
   // R7
   shift_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_phase |-> (rx_inhibit == '0 && tx_hold == '0 && mc_hold == '0));
   // R3
   rx_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ($countones(rx_inhibit) == NUM_DOM - 1));
   // R4
   tx_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_hold & ~rx_inhibit) == '0);
   // R6
   mc_needs_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ((~mc_hold & ~burst_act) == '0));
endmodule

// File: tb/test_xdom_capture_hold.sv
module test_xdom_capture_hold;
   localparam int ND   = 3;
   localparam int MCN  = 3;
   localparam int HOLD = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          test_mode = 1'b0;
   logic          shift_phase = 1'b0;
   logic          shift_tick = 1'b0;
   logic [1:0]    dom_sel = '0;
   logic [ND-1:0] burst_act = '0;
   logic [ND-1:0] cap_stb = '0;
   logic [ND-1:0] rx_inhibit, tx_hold, mc_hold;

   int vecs = 0;
   int errs = 0;

   // reference state, built from the requirements
   int m_sel;
   int m_cnt;
   bit m_armed;
   bit m_rel;
   int m_ph [ND];

   always #5 clk = ~clk;

   xdom_capture_hold #(.NUM_DOM(ND), .MC_N(MCN), .HOLD_TICKS(HOLD)) i_xdom_capture_hold (
      .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .shift_phase(shift_phase),
      .shift_tick(shift_tick), .dom_sel(dom_sel), .burst_act(burst_act),
      .cap_stb(cap_stb), .rx_inhibit(rx_inhibit), .tx_hold(tx_hold), .mc_hold(mc_hold)
   );

   // pattern table: {sel[31:28], len[27:20], bmask[19:16], cmask[15:12], post[11:4], tickp[3:0]}
   localparam int NPAT = 6;
   localparam logic [31:0] PATS [NPAT] = '{
      {4'd0, 8'd6,  4'h7, 4'h1, 8'd40, 4'd2},
      {4'd2, 8'd9,  4'h5, 4'h4, 8'd30, 4'd3},
      {4'd1, 8'd12, 4'h7, 4'h1, 8'd20, 4'd1},
      {4'd1, 8'd3,  4'h2, 4'h2, 8'd12, 4'd1},
      {4'd2, 8'd6,  4'h7, 4'h7, 8'd25, 4'd4},
      {4'd0, 8'd2,  4'h1, 4'h1, 8'd5,  4'd1}
   };

   task automatic model_reset();
      m_sel = 0; m_cnt = 0; m_armed = 0; m_rel = 0;
      for (int d = 0; d < ND; d++) m_ph[d] = 0;
   endtask

   task automatic check_now(input string ctx);
      logic [ND-1:0] e_rx, e_tx, e_mc;
      bit run;
      run = test_mode && !shift_phase;
      for (int d = 0; d < ND; d++) begin
         e_rx[d] = run && (d != m_sel);
         e_tx[d] = run && (d != m_sel) && !m_rel;
         e_mc[d] = run && !(burst_act[d] && (m_ph[d] == MCN - 1));
      end
      vecs++;
      if (rx_inhibit !== e_rx) begin
         errs++;
         $display("FAIL R3 [%s] rx_inhibit got %b exp %b", ctx, rx_inhibit, e_rx);
      end
      if (tx_hold !== e_tx) begin
         errs++;
         $display("FAIL R4 R5 [%s] tx_hold got %b exp %b", ctx, tx_hold, e_tx);
      end
      if (mc_hold !== e_mc) begin
         errs++;
         $display("FAIL R6 [%s] mc_hold got %b exp %b", ctx, mc_hold, e_mc);
      end
   endtask

   task automatic model_step();
      if (!test_mode || shift_phase) begin
         if (test_mode && shift_phase && dom_sel < ND) m_sel = dom_sel;
         m_armed = 0; m_rel = 0; m_cnt = 0;
         for (int d = 0; d < ND; d++) m_ph[d] = 0;
      end else begin
         for (int d = 0; d < ND; d++)
            if (burst_act[d]) m_ph[d] = (m_ph[d] == MCN - 1) ? 0 : m_ph[d] + 1;
         if (m_armed) begin
            if (shift_tick) begin
               if (m_cnt == 1) begin m_rel = 1; m_armed = 0; m_cnt = 0; end
               else m_cnt--;
            end
         end else if (!m_rel && cap_stb[m_sel]) begin
            m_armed = 1; m_cnt = HOLD;
         end
      end
   endtask

   task automatic step(input bit tm, input bit sh, input bit tk, input logic [1:0] ds,
                       input logic [ND-1:0] ba, input logic [ND-1:0] cs, input string ctx);
      @(negedge clk);
      test_mode = tm; shift_phase = sh; shift_tick = tk;
      dom_sel = ds; burst_act = ba; cap_stb = cs;
      #1;
      check_now(ctx);
      model_step();
   endtask

   task automatic run_pat(input logic [31:0] e);
      logic [1:0] sel, other;
      int len, post, tp;
      sel   = e[29:28];
      other = sel + 2'd1;
      len   = int'(e[27:20]);
      post  = int'(e[11:4]);
      tp    = int'(e[3:0]);
      for (int k = 0; k < 5; k++)
         step(1, 1, (k % tp) == 0, sel, '0, '0, "R7 shift");
      // select code changes during burst must be ignored (R2)
      for (int k = 0; k < len; k++)
         step(1, 0, (k % tp) == 0, other, e[16 +: ND],
              (k == len - 1) ? e[12 +: ND] : '0, "R2 R6 burst");
      for (int k = 0; k < post; k++)
         step(1, 0, (k % tp) == 0, other, '0, '0, "R5 release");
   endtask

   initial begin
      #2_000_000;
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      model_reset();
      test_mode = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen with test mode high, shift low
      step(1, 0, 0, 2'd0, '0, '0, "R1 reset");

      foreach (PATS[i]) run_pat(PATS[i]);

      // R2: out-of-range code during shift keeps domain 2
      for (int k = 0; k < 3; k++) step(1, 1, 0, 2'd2, '0, '0, "R2 load");
      for (int k = 0; k < 3; k++) step(1, 1, 0, 2'd3, '0, '0, "R2 bad code");
      for (int k = 0; k < 4; k++) step(1, 0, 0, 2'd3, '1, '0, "R2 check");

      // R8: test mode low blocks everything and clears window and phases
      step(1, 0, 0, 2'd0, '1, 3'b100, "R5 arm");
      for (int k = 0; k < 4; k++) step(1, 0, 1, 2'd0, '0, '0, "R5 count");
      for (int k = 0; k < 6; k++) step(0, 0, 1, 2'd1, '1, '1, "R8 off");
      for (int k = 0; k < 6; k++) step(0, 1, 1, 2'd0, '1, '1, "R8 off shift");
      for (int k = 0; k < 7; k++) step(1, 0, 0, 2'd1, '1, '0, "R8 back on");

      // R7: a new shift cuts an open window short
      step(1, 0, 0, 2'd0, '0, 3'b100, "R7 arm");
      for (int k = 0; k < 3; k++) step(1, 0, 1, 2'd0, '0, '0, "R7 count");
      for (int k = 0; k < 3; k++) step(1, 1, 1, 2'd0, '1, '1, "R7 cut");
      for (int k = 0; k < 12; k++) step(1, 0, 1, 2'd1, 3'b011, '0, "R7 after");

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule